// File: doc/BRIEF.md
# Receive Ring Frame Writer

This block takes received Ethernet frames as a byte stream and lays them into a circular byte ring in memory, through a 32-bit write port with byte enables. Each stored record is a 32-bit status word followed by the frame bytes, including the trailing 4-byte CRC. Every record begins on a 4-byte boundary. The status word carries the stored byte count in its upper half and the receive outcome flags in its lower half.

Before any byte of a frame lands in the ring, the header at the write offset already holds the busy length 0xFFF0. A host that reads a header while a frame is still being copied can therefore tell it is unfinished. The host frees space by writing its read offset minus a fixed bias of 16. The block adds the bias back modulo the ring size and raises an empty flag when the read and write offsets match. A frame that would crowd the read offset is abandoned. In that case the write offset does not move and an overflow pulse is raised.

The stream must leave at least two idle cycles after each frame's last byte, and after reset, before the next frame's first byte. Error flags are sampled with the last byte.

Top module: `rx_ring_writer`

## Requirements
- R1: After reset the write offset is 0, the empty flag is 1, no event is raised, and within three cycles the word at offset 0 holds the busy header 0xFFF0_0000.
- R2: A host write of value V sets the read offset to (V + 16) mod ring size. The empty flag is 1 exactly when the read offset equals the write offset, and an empty ring offers its full size to the next frame.
- R3: Until a frame is sealed, the header word at its record start reads length 0xFFF0 with all status bits 0. This holds while its bytes are being copied.
- R4: Frame bytes, CRC included, are stored in arrival order from record start + 4 and wrap from the last ring byte to offset 0. Each byte is a single-lane write.
- R5: The sealed header holds the byte count in bits 31:16 and the status in bits 15:0. Bit 0 is OK, set when no error flag is set. Bits 5:1 copy the input flags: bit 1 alignment, bit 2 CRC, bit 3 giant, bit 4 runt, bit 5 bad symbol. Bits 15:6 are 0.
- R6: On sealing, the write offset advances by 4 + length, rounded up to a multiple of 4, modulo the ring size. It is always a multiple of 4.
- R7: Each sealed frame raises exactly one one-cycle pulse: receive-OK when no error flag is set, receive-error otherwise. The two never coincide.
- R8: If the byte count plus 8 would exceed the free space (read minus write offset, modulo the ring size), the frame is dropped. The write offset stays put, the header stays busy, one overflow pulse is raised, the remaining bytes are ignored, and nothing at or past the read offset is written.
- R9: Room is judged against the read offset current at each byte's arrival, so a read-offset update accepted with a frame's first byte is honoured for that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Byte strobe |
| rx_byte | input | 8 | Frame byte |
| rx_last | input | 1 | Marks the frame's final byte |
| rx_err | input | 5 | Error flags, valid with rx_last: [0] align, [1] CRC, [2] giant, [3] runt, [4] bad symbol |
| host_rd_we | input | 1 | Host read-offset write strobe |
| host_rd_val | input | 16 | Host read offset minus 16 |
| ring_empty | output | 1 | Read offset equals write offset |
| wr_off | output | RING_AW (8) | Current write offset in bytes |
| mem_we | output | 1 | Memory write strobe |
| mem_waddr | output | RING_AW-2 (6) | Word address |
| mem_be | output | 4 | Byte lane enables |
| mem_wdata | output | 32 | Write data |
| ev_rx_ok | output | 1 | Frame sealed without error |
| ev_rx_err | output | 1 | Frame sealed with error flags |
| ev_overflow | output | 1 | Frame dropped for lack of room |

## Verification
Two functions can fall in the same cycle: the host moving the read offset, and the room check on an incoming byte. The bench provokes this by issuing the read-offset write in the same cycle as a frame's first byte. The ring at that moment is too full for the frame unless the new offset counts for the later bytes. The result is judged by whether that frame is sealed with the right final write offset and contents, or wrongly dropped.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
    typedef enum logic [2:0] {
        WS_ARM,
        WS_IDLE,
        WS_COPY,
        WS_DROP,
        WS_SEAL
    } wr_state_e;

    localparam int          ERR_W    = 5;
    localparam logic [15:0] BUSY_LEN = 16'hFFF0;
endpackage

// File: rtl/rxr_hostptr.sv
module rxr_hostptr #(
    parameter int AW   = 8,
    parameter int BIAS = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [15:0]   val,
    output logic [AW-1:0] rd_off
);
    logic [AW-1:0] rd_d, rd_q;
    logic [15:0]   sum;
    logic          sum_unused;

    assign sum        = val + 16'(BIAS);
    assign sum_unused = ^sum;

    always_comb begin
        rd_d = rd_q;
        if (we) rd_d = sum[AW-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rd_off = rd_q;
endmodule

// File: rtl/rxr_space.sv
module rxr_space #(
    parameter int AW = 8
) (
    input  logic [AW-1:0] wp,
    input  logic [AW-1:0] rd,
    output logic          empty,
    output logic [AW:0]   free
);
    logic [AW-1:0] diff;

    assign diff  = rd - wp;
    assign empty = (diff == '0);
    assign free  = empty ? {1'b1, {AW{1'b0}}} : {1'b0, diff};
endmodule

// File: rtl/rxr_writer.sv
module rxr_writer
    import rxr_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    input  logic             in_last,
    input  logic [ERR_W-1:0] in_err,
    input  logic [AW:0]      free,
    output logic [AW-1:0]    wp,
    output logic             mem_we,
    output logic [AW-3:0]    mem_addr,
    output logic [3:0]       mem_be,
    output logic [31:0]      mem_wdata,
    output logic             ev_ok,
    output logic             ev_err,
    output logic             ev_ovf
);
    typedef struct packed {
        wr_state_e        st;
        logic [AW-1:0]    wp;
        logic [AW-1:0]    cur;
        logic [15:0]      cnt;
        logic [ERR_W-1:0] err;
        logic             mem_we;
        logic [AW-3:0]    mem_addr;
        logic [3:0]       mem_be;
        logic [31:0]      mem_wdata;
        logic             ev_ok;
        logic             ev_err;
        logic             ev_ovf;
    } wr_regs_t;

    wr_regs_t      d, q;
    logic [AW-1:0] base_cur;
    logic [15:0]   base_cnt;
    logic [17:0]   need;
    logic          fits;
    logic [17:0]   rec;
    logic          rec_unused;
    logic [15:0]   status;

    assign rec_unused = ^rec;

    always_comb begin
        d        = q;
        d.mem_we = 1'b0;
        d.ev_ok  = 1'b0;
        d.ev_err = 1'b0;
        d.ev_ovf = 1'b0;

        base_cur = (q.st == WS_IDLE) ? q.wp + AW'(4) : q.cur;
        base_cnt = (q.st == WS_IDLE) ? 16'd0 : q.cnt;
        need     = 18'(base_cnt) + 18'd9;
        fits     = (need <= 18'(free));
        rec      = (18'(q.cnt) + 18'd7) & ~18'd3;
        status   = {10'd0, q.err, ~|q.err};

        unique case (q.st)
            WS_ARM: begin
                d.mem_we    = 1'b1;
                d.mem_addr  = q.wp[AW-1:2];
                d.mem_be    = 4'hF;
                d.mem_wdata = {BUSY_LEN, 16'h0000};
                d.st        = WS_IDLE;
            end
            WS_IDLE, WS_COPY: begin
                if (in_valid) begin
                    if (fits) begin
                        d.mem_we    = 1'b1;
                        d.mem_addr  = base_cur[AW-1:2];
                        d.mem_be    = 4'b0001 << base_cur[1:0];
                        d.mem_wdata = {4{in_data}};
                        d.cur       = base_cur + AW'(1);
                        d.cnt       = base_cnt + 16'd1;
                        if (in_last) begin
                            d.err = in_err;
                            d.st  = WS_SEAL;
                        end else begin
                            d.st  = WS_COPY;
                        end
                    end else begin
                        d.ev_ovf = 1'b1;
                        d.st     = in_last ? WS_IDLE : WS_DROP;
                    end
                end
            end
            WS_DROP: begin
                if (in_valid && in_last) d.st = WS_IDLE;
            end
            WS_SEAL: begin
                d.mem_we    = 1'b1;
                d.mem_addr  = q.wp[AW-1:2];
                d.mem_be    = 4'hF;
                d.mem_wdata = {q.cnt, status};
                d.wp        = q.wp + rec[AW-1:0];
                d.ev_ok     = ~|q.err;
                d.ev_err    = |q.err;
                d.st        = WS_ARM;
            end
            default: d.st = WS_ARM;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= WS_ARM;
        end else begin
            q    <= d;
        end
    end

    assign wp        = q.wp;
    assign mem_we    = q.mem_we;
    assign mem_addr  = q.mem_addr;
    assign mem_be    = q.mem_be;
    assign mem_wdata = q.mem_wdata;
    assign ev_ok     = q.ev_ok;
    assign ev_err    = q.ev_err;
    assign ev_ovf    = q.ev_ovf;
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
    import rxr_pkg::*;
#(
    parameter int RING_AW = 8,
    parameter int RD_BIAS = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rx_valid,
    input  logic [7:0]         rx_byte,
    input  logic               rx_last,
    input  logic [ERR_W-1:0]   rx_err,
    input  logic               host_rd_we,
    input  logic [15:0]        host_rd_val,
    output logic               ring_empty,
    output logic [RING_AW-1:0] wr_off,
    output logic               mem_we,
    output logic [RING_AW-3:0] mem_waddr,
    output logic [3:0]         mem_be,
    output logic [31:0]        mem_wdata,
    output logic               ev_rx_ok,
    output logic               ev_rx_err,
    output logic               ev_overflow
);
    logic [RING_AW-1:0] rd_off;
    logic [RING_AW:0]   free_bytes;

    rxr_hostptr #(.AW(RING_AW), .BIAS(RD_BIAS)) u_hostptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (host_rd_we),
        .val    (host_rd_val),
        .rd_off (rd_off)
    );

    rxr_space #(.AW(RING_AW)) u_space (
        .wp    (wr_off),
        .rd    (rd_off),
        .empty (ring_empty),
        .free  (free_bytes)
    );

    rxr_writer #(.AW(RING_AW)) u_writer (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (rx_valid),
        .in_data   (rx_byte),
        .in_last   (rx_last),
        .in_err    (rx_err),
        .free      (free_bytes),
        .wp        (wr_off),
        .mem_we    (mem_we),
        .mem_addr  (mem_waddr),
        .mem_be    (mem_be),
        .mem_wdata (mem_wdata),
        .ev_ok     (ev_rx_ok),
        .ev_err    (ev_rx_err),
        .ev_ovf    (ev_overflow)
    );
endmodule

// File: rtl/rx_ring_writer_chk.sv
module rx_ring_writer_chk #(
    parameter int RING_AW = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               host_rd_we,
    input logic               ring_empty,
    input logic [RING_AW-1:0] wr_off,
    input logic               mem_we,
    input logic [3:0]         mem_be,
    input logic               ev_rx_ok,
    input logic               ev_rx_err,
    input logic               ev_overflow
);
    // R6
    wp_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_off[1:0] == 2'b00);

    // R7
    evt_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ev_rx_ok && ev_rx_err));

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_overflow |-> (wr_off == $past(wr_off)) && !ev_rx_ok && !ev_rx_err);

    // R6
    wp_moves_on_seal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_off != $past(wr_off)) |-> (ev_rx_ok || ev_rx_err));

    // R4
    lane_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ($onehot(mem_be) || mem_be == 4'hF));

    // R8
    gap_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ev_rx_ok || ev_rx_err) && !$past(host_rd_we)) |-> !ring_empty);
endmodule

bind rx_ring_writer rx_ring_writer_chk #(.RING_AW(RING_AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_rd_we  (host_rd_we),
    .ring_empty  (ring_empty),
    .wr_off      (wr_off),
    .mem_we      (mem_we),
    .mem_be      (mem_be),
    .ev_rx_ok    (ev_rx_ok),
    .ev_rx_err   (ev_rx_err),
    .ev_overflow (ev_overflow)
);

// File: tb/tb_rx_ring_writer.sv
`timescale 1ns/1ps
module tb_rx_ring_writer;
    localparam int RB = 256;

    typedef struct packed {
        logic        rd_we;
        logic [15:0] rd_val;
        logic [15:0] len;
        logic [4:0]  err;
        logic [7:0]  exp_wp;
        logic [1:0]  kind;   // 0 ok, 1 error, 2 dropped
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{1'b0, 16'd0,   16'd10,  5'b00000, 8'd16,  2'd0},
        '{1'b0, 16'd0,   16'd61,  5'b00010, 8'd84,  2'd1},
        '{1'b0, 16'd0,   16'd64,  5'b00000, 8'd152, 2'd0},
        '{1'b0, 16'd0,   16'd7,   5'b11000, 8'd164, 2'd1},
        '{1'b1, 16'd144, 16'd100, 5'b00000, 8'd12,  2'd0},
        '{1'b0, 16'd0,   16'd141, 5'b00000, 8'd12,  2'd2},
        '{1'b0, 16'd0,   16'd140, 5'b00001, 8'd156, 2'd1},
        '{1'b0, 16'd0,   16'd5,   5'b00000, 8'd156, 2'd2}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rx_last = 1'b0;
    logic [4:0]  rx_err = '0;
    logic        host_rd_we = 1'b0;
    logic [15:0] host_rd_val = '0;
    logic        ring_empty;
    logic [7:0]  wr_off;
    logic        mem_we;
    logic [5:0]  mem_waddr;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata;
    logic        ev_rx_ok, ev_rx_err, ev_overflow;

    int checks = 0;
    int failures = 0;
    int n_ok = 0, n_err = 0, n_ovf = 0;
    bit done = 1'b0;
    logic [31:0] mem [64];

    always #2 clk = ~clk;

    rx_ring_writer dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .rx_last(rx_last), .rx_err(rx_err), .host_rd_we(host_rd_we),
        .host_rd_val(host_rd_val), .ring_empty(ring_empty), .wr_off(wr_off),
        .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .ev_rx_ok(ev_rx_ok), .ev_rx_err(ev_rx_err),
        .ev_overflow(ev_overflow)
    );

    initial for (int k = 0; k < 64; k++) mem[k] = '0;

    always @(negedge clk) begin
        if (mem_we)
            for (int b = 0; b < 4; b++)
                if (mem_be[b]) mem[mem_waddr][8*b +: 8] <= mem_wdata[8*b +: 8];
        if (rst_n) begin
            if (ev_rx_ok)    n_ok++;
            if (ev_rx_err)   n_err++;
            if (ev_overflow) n_ovf++;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int idx, input int j);
        return 8'(j * 7 + idx * 13 + 1);
    endfunction

    function automatic logic [7:0] mbyte(input int o);
        int w = (o % RB) / 4;
        int l = o % 4;
        return mem[w][8*l +: 8];
    endfunction

    task automatic send_frame(input int idx, input int len, input logic [4:0] err,
                              input logic we, input logic [15:0] rv, input logic [7:0] start);
        for (int j = 0; j < len; j++) begin
            @(negedge clk);
            if (len >= 4 && j == len / 2)
                chk(mem[start / 4] == 32'hFFF0_0000, "R3 busy header during copy", mem[start / 4], 32'hFFF0_0000);
            rx_valid    = 1'b1;
            rx_byte     = pat(idx, j);
            rx_last     = (j == len - 1);
            rx_err      = (j == len - 1) ? err : 5'd0;
            host_rd_we  = (j == 0) && we;
            host_rd_val = rv;
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_last = 1'b0; rx_err = '0; host_rd_we = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int rd_model;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk(wr_off == 8'd0, "R1 reset write offset", 32'(wr_off), 32'd0);
        chk(ring_empty == 1'b1, "R1 reset empty", 32'(ring_empty), 32'd1);
        chk({ev_rx_ok, ev_rx_err, ev_overflow} == 3'b000, "R1 reset events",
            32'({ev_rx_ok, ev_rx_err, ev_overflow}), 32'd0);
        repeat (3) @(negedge clk);
        chk(mem[0] == 32'hFFF0_0000, "R1 busy header at offset 0", mem[0], 32'hFFF0_0000);
        rd_model = 0;

        for (int i = 0; i < 8; i++) begin
            logic [7:0]  old_wp;
            logic [31:0] snap, hdr;
            int c_ok, c_err, c_ovf, bad;
            old_wp = wr_off;
            snap   = mem[rd_model / 4];
            c_ok = n_ok; c_err = n_err; c_ovf = n_ovf;
            if (VEC[i].rd_we) rd_model = (int'(VEC[i].rd_val) + 16) % RB;
            send_frame(i, int'(VEC[i].len), VEC[i].err, VEC[i].rd_we, VEC[i].rd_val, old_wp);

            chk(wr_off == VEC[i].exp_wp, (VEC[i].kind == 2) ? "R8 write offset held" : "R6 write offset advance",
                32'(wr_off), 32'(VEC[i].exp_wp));
            if (i == 4)
                chk(n_ovf == c_ovf && wr_off == 8'd12, "R9 pointer update with first byte honoured",
                    32'(wr_off), 32'd12);
            if (VEC[i].kind == 2) begin
                chk(n_ovf - c_ovf == 1 && n_ok == c_ok && n_err == c_err, "R8 overflow pulse only",
                    32'(n_ovf - c_ovf), 32'd1);
                chk(mem[old_wp / 4] == 32'hFFF0_0000, "R8 header stays busy", mem[old_wp / 4], 32'hFFF0_0000);
                chk(mem[rd_model / 4] == snap, "R8 read region untouched", mem[rd_model / 4], snap);
            end else begin
                chk(n_ok - c_ok == ((VEC[i].kind == 0) ? 1 : 0) &&
                    n_err - c_err == ((VEC[i].kind == 1) ? 1 : 0) && n_ovf == c_ovf,
                    "R7 completion event", 32'({n_ok - c_ok, n_err - c_err}), 32'(VEC[i].kind));
                hdr = {VEC[i].len, 10'd0, VEC[i].err, VEC[i].err == 5'd0};
                chk(mem[old_wp / 4] == hdr, "R5 sealed header", mem[old_wp / 4], hdr);
                bad = 0;
                for (int j = 0; j < int'(VEC[i].len); j++)
                    if (mbyte(int'(old_wp) + 4 + j) != pat(i, j)) bad++;
                chk(bad == 0, "R4 stored bytes incl wrap", 32'(bad), 32'd0);
                chk(mem[VEC[i].exp_wp / 4] == 32'hFFF0_0000, "R3 busy header at next record",
                    mem[VEC[i].exp_wp / 4], 32'hFFF0_0000);
            end
        end

        // R2: bias and empty detection, write offset now 156
        @(negedge clk); host_rd_we = 1'b1; host_rd_val = 16'd140;
        @(negedge clk); host_rd_we = 1'b0;
        chk(ring_empty == 1'b1, "R2 biased offset equals write offset", 32'(ring_empty), 32'd1);
        @(negedge clk); host_rd_we = 1'b1; host_rd_val = 16'd0;
        @(negedge clk); host_rd_we = 1'b0;
        chk(ring_empty == 1'b0, "R2 offset 16 not empty", 32'(ring_empty), 32'd0);
        @(negedge clk); host_rd_we = 1'b1; host_rd_val = 16'hFF8C;
        @(negedge clk); host_rd_we = 1'b0;
        chk(ring_empty == 1'b1, "R2 bias sum wraps modulo ring", 32'(ring_empty), 32'd1);
        send_frame(9, 20, 5'd0, 1'b0, 16'd0, 8'd156);
        chk(wr_off == 8'd180, "R2 empty ring gives full room", 32'(wr_off), 32'd180);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule